// File: doc/BRIEF.md
# Configuration Port Transfer Controller

This block sits between a processor's memory-mapped register space and an internal configuration port that accepts and returns 32-bit words. Software loads configuration words into a write FIFO and then sets a start bit; the block streams the FIFO contents to the port one word per cycle until it is empty. For readback, software programs a word count and sets a second start bit; the block pulls exactly that many words from the port into a read FIFO, from which software reads them one at a time.

Start bits clear themselves when their operation finishes, so software polls the control or status register to learn when it may start the next one. An abort command interrupts a running transfer by flipping the port's direction select while the port stays enabled. It then gathers the four status bytes the port returns on its low byte lane into a single packed word. Both FIFOs are flushed at the end of an abort.

Back-pressure works as follows. The write FIFO refuses (drops) words written while it is full. During readback the controller lowers the port enable and stalls while the read FIFO is full. It resumes on the first cycle a slot frees up, so no returned word is lost.

Top module: `cfgport_xfer_ctrl`

## Requirements
- R1: After reset the status register (0x110) reads 0x5 when the end-of-startup input is high, vacancy (0x114) reads WR_DEPTH-1, and occupancy (0x118), abort status (0x11C) and control (0x10C) read 0. The port enable is low.
- R2: Writing 1 to control bit 0 sends every write-FIFO word to the port in order, with enable high and direction low (0 = write). When the FIFO is empty, bit 0 clears and status bit 0 (done) returns to 1.
- R3: Writing control bit 1 moves exactly size[11:0] words from the port into the read FIFO, with direction high (1 = read), and then clears bit 1. Size bits above 11 are ignored.
- R4: While the read FIFO holds RD_DEPTH-1 words, the readback stalls with done at 0. It resumes as software pops words, and every returned word arrives in port order.
- R5: A write to control bits 0 or 1 is ignored while either start bit or the abort bit is set. When bits 0 and 1 are written together, only the write transfer starts.
- R6: No port access starts while the end-of-startup input is low; a pending start waits. Status bit 2 mirrors that input.
- R7: An abort (control bit 4) during a transfer holds the enable high for one cycle with the direction inverted. It then stores the low port byte of the next four cycles into 0x11C, first byte in bits 31:24 and last in bits 7:0. It then flushes both FIFOs and clears the control bits.
- R8: An abort while idle completes in one cycle. It flushes both FIFOs, leaves 0x11C unchanged and drives no port access.
- R9: Control bit 2 flushes both FIFOs. Control bit 3 returns size, control, abort status and both FIFOs to their reset values. Both bits read back as 0.
- R10: A word written to 0x100 while the write FIFO holds WR_DEPTH-1 words is dropped. A read of 0x104 with the read FIFO empty returns 0.
- R11: Register read data appears on reg_rdata in the cycle after reg_rd_en. Unmapped offsets return 0, and control bits 31:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after the strobe |
| startup_done | input | 1 | End-of-startup indication; gates port access |
| port_en | output | 1 | Configuration port enable |
| port_rdwr | output | 1 | Port direction: 1 read, 0 write |
| port_wdata | output | DW | Word sent to the port |
| port_rdata | input | DW | Word returned by the port; bits 7:0 carry abort status |

## Verification
On every cycle, the assertions check the following:
- the port stays quiet while idle with end-of-startup low;
- an abort cycle really inverts the direction with the enable high;
- readback never pushes past the programmed count;
- the two start bits are never both set;
- a full write FIFO never grows;
- control reads keep their upper bits clear.

Only the bench scenarios can show the rest: word ordering end to end, the exact abort byte packing, the stall and resume under a full read FIFO, dropped starts and dropped words, and what soft reset and FIFO clear leave behind.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int OFS_WFIFO  = 'h100;
  localparam int OFS_RFIFO  = 'h104;
  localparam int OFS_SIZE   = 'h108;
  localparam int OFS_CTRL   = 'h10C;
  localparam int OFS_STATUS = 'h110;
  localparam int OFS_VACANT = 'h114;
  localparam int OFS_OCCUP  = 'h118;
  localparam int OFS_ABORT  = 'h11C;

  localparam int CB_WRITE = 0;
  localparam int CB_READ  = 1;
  localparam int CB_FLUSH = 2;
  localparam int CB_SRST  = 3;
  localparam int CB_ABORT = 4;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WRITE, SQ_READ, SQ_ABT_TOG, SQ_ABT_CAP
  } seq_state_e;
endpackage

// File: rtl/cfgx_fifo.sv
module cfgx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic                     full,
  output logic                     empty,
  output logic [$clog2(DEPTH)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] USABLE = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign full    = (count == USABLE);
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
#(
  parameter int SZW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           srst,
  input  logic           start_wr,
  input  logic           start_rd,
  input  logic           abort_req,
  input  logic           eos,
  input  logic [SZW-1:0] size,
  input  logic           wf_empty,
  input  logic           rf_full,
  input  logic [7:0]     stat_byte,
  output logic           port_en,
  output logic           port_rdwr,
  output logic           wf_pop,
  output logic           rf_push,
  output logic           op_done,
  output logic           flush,
  output logic           busy,
  output logic [31:0]    abort_word
);
  seq_state_e     st, st_n;
  logic [SZW-1:0] cnt;
  logic [1:0]     cap_idx;
  logic           op_rd;

  assign busy = (st != SQ_IDLE);

  always_comb begin
    st_n = st; port_en = 1'b0; port_rdwr = 1'b0;
    wf_pop = 1'b0; rf_push = 1'b0; op_done = 1'b0; flush = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        if (abort_req) begin
          op_done = 1'b1; flush = 1'b1;
        end else if (eos && start_wr) st_n = SQ_WRITE;
        else if (eos && start_rd)     st_n = SQ_READ;
      end
      SQ_WRITE: begin
        port_en = !wf_empty;
        wf_pop  = !wf_empty;
        if (abort_req) st_n = SQ_ABT_TOG;
        else if (wf_empty) begin
          op_done = 1'b1; st_n = SQ_IDLE;
        end
      end
      SQ_READ: begin
        port_rdwr = 1'b1;
        port_en   = (cnt != size) && !rf_full;
        rf_push   = port_en;
        if (abort_req) st_n = SQ_ABT_TOG;
        else if (cnt == size) begin
          op_done = 1'b1; st_n = SQ_IDLE;
        end
      end
      SQ_ABT_TOG: begin
        port_en   = 1'b1;
        port_rdwr = !op_rd;
        st_n      = SQ_ABT_CAP;
      end
      SQ_ABT_CAP: begin
        if (cap_idx == 2'd3) begin
          op_done = 1'b1; flush = 1'b1; st_n = SQ_IDLE;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; cnt <= '0; cap_idx <= '0; op_rd <= 1'b0; abort_word <= '0;
    end else if (srst) begin
      st <= SQ_IDLE; cnt <= '0; cap_idx <= '0; op_rd <= 1'b0; abort_word <= '0;
    end else begin
      st <= st_n;
      if (st == SQ_IDLE) begin
        cnt     <= '0;
        cap_idx <= '0;
        op_rd   <= (st_n == SQ_READ);
      end
      if (rf_push) cnt <= cnt + 1'b1;
      if (st == SQ_ABT_CAP) begin
        abort_word <= {abort_word[23:0], stat_byte};
        cap_idx    <= cap_idx + 1'b1;
      end
    end
  end

  // R6
  no_early_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && !eos) |=> !port_en);
  // R7
  abort_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_ABT_TOG) |-> (port_en && port_rdwr != $past(port_rdwr)));
  // R3
  read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_push |-> (cnt < size));
endmodule

// File: rtl/cfgport_xfer_ctrl.sv
module cfgport_xfer_ctrl
  import cfgx_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 9,
  parameter int WR_DEPTH = 64,
  parameter int RD_DEPTH = 128,
  parameter int SZW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic          reg_rd_en,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          startup_done,
  output logic          port_en,
  output logic          port_rdwr,
  output logic [DW-1:0] port_wdata,
  input  logic [DW-1:0] port_rdata
);
  localparam int WCW = $clog2(WR_DEPTH);
  localparam int RCW = $clog2(RD_DEPTH);
  localparam logic [WCW-1:0] WR_USABLE = WCW'(WR_DEPTH - 1);

  logic           ctrl_wr, ctrl_rd, ctrl_abt;
  logic           srst_q, fclr_q;
  logic [SZW-1:0] size_q;
  logic           wf_full, wf_empty, wf_pop, rf_full, rf_empty, rf_push;
  logic [WCW-1:0] wf_count;
  logic [RCW-1:0] rf_count;
  logic [DW-1:0]  rf_dout;
  logic           op_done, flush, busy, fifo_clr;
  logic [31:0]    abort_word;
  logic           hit_wfifo, hit_rfifo, hit_ctrl, hit_size;

  assign hit_wfifo = reg_wr_en && (reg_addr == AW'(OFS_WFIFO));
  assign hit_size  = reg_wr_en && (reg_addr == AW'(OFS_SIZE));
  assign hit_ctrl  = reg_wr_en && (reg_addr == AW'(OFS_CTRL));
  assign hit_rfifo = reg_rd_en && (reg_addr == AW'(OFS_RFIFO));
  assign fifo_clr  = srst_q || fclr_q || flush;

  cfgx_fifo #(.W(DW), .DEPTH(WR_DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(hit_wfifo), .din(reg_wdata), .pop(wf_pop), .dout(port_wdata),
    .full(wf_full), .empty(wf_empty), .count(wf_count));

  cfgx_fifo #(.W(DW), .DEPTH(RD_DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(rf_push), .din(port_rdata), .pop(hit_rfifo), .dout(rf_dout),
    .full(rf_full), .empty(rf_empty), .count(rf_count));

  cfgx_seq #(.SZW(SZW)) u_seq (
    .clk(clk), .rst_n(rst_n), .srst(srst_q),
    .start_wr(ctrl_wr), .start_rd(ctrl_rd), .abort_req(ctrl_abt),
    .eos(startup_done), .size(size_q),
    .wf_empty(wf_empty), .rf_full(rf_full), .stat_byte(port_rdata[7:0]),
    .port_en(port_en), .port_rdwr(port_rdwr),
    .wf_pop(wf_pop), .rf_push(rf_push), .op_done(op_done), .flush(flush),
    .busy(busy), .abort_word(abort_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_wr <= 1'b0; ctrl_rd <= 1'b0; ctrl_abt <= 1'b0;
      srst_q <= 1'b0; fclr_q <= 1'b0; size_q <= '0;
    end else begin
      srst_q <= hit_ctrl && reg_wdata[CB_SRST];
      fclr_q <= hit_ctrl && reg_wdata[CB_FLUSH];
      if (srst_q) begin
        ctrl_wr <= 1'b0; ctrl_rd <= 1'b0; ctrl_abt <= 1'b0; size_q <= '0;
      end else begin
        if (op_done) begin
          ctrl_wr <= 1'b0; ctrl_rd <= 1'b0; ctrl_abt <= 1'b0;
        end
        if (hit_ctrl) begin
          if (reg_wdata[CB_ABORT]) ctrl_abt <= 1'b1;
          if (!ctrl_wr && !ctrl_rd && !ctrl_abt) begin
            ctrl_wr <= reg_wdata[CB_WRITE];
            ctrl_rd <= reg_wdata[CB_READ] && !reg_wdata[CB_WRITE];
          end
        end
        if (hit_size) size_q <= reg_wdata[SZW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd_en) begin
      reg_rdata <= '0;
      case (reg_addr)
        AW'(OFS_RFIFO):  reg_rdata <= rf_empty ? '0 : rf_dout;
        AW'(OFS_SIZE):   reg_rdata <= DW'(size_q);
        AW'(OFS_CTRL):   reg_rdata <= DW'({ctrl_abt, 2'b00, ctrl_rd, ctrl_wr});
        AW'(OFS_STATUS): reg_rdata <= DW'({startup_done, 1'b0, !busy});
        AW'(OFS_VACANT): reg_rdata <= DW'(WR_USABLE - wf_count);
        AW'(OFS_OCCUP):  reg_rdata <= DW'(rf_count);
        AW'(OFS_ABORT):  reg_rdata <= DW'(abort_word);
        default:         reg_rdata <= '0;
      endcase
    end
  end

  // R5
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, ctrl_rd}));
  // R11
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == AW'(OFS_CTRL)) |=> (reg_rdata[DW-1:5] == '0));
endmodule

// File: tb/tb_cfgport_xfer_ctrl.sv
module tb_cfgport_xfer_ctrl;
  localparam int WR_DEPTH = 64;
  localparam int RD_DEPTH = 128;
  localparam logic [31:0] RBASE = 32'h5EED_0000;

  typedef struct packed {
    logic        wr;
    logic [8:0]  addr;
    logic [31:0] val;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 9'h110, 32'h5,         8'd1},
    '{1'b0, 9'h114, 32'h3F,        8'd1},
    '{1'b0, 9'h118, 32'h0,         8'd1},
    '{1'b0, 9'h11C, 32'h0,         8'd1},
    '{1'b0, 9'h10C, 32'h0,         8'd1},
    '{1'b0, 9'h104, 32'h0,         8'd10},
    '{1'b0, 9'h000, 32'h0,         8'd11},
    '{1'b1, 9'h108, 32'hFFFF_FABC, 8'd3},
    '{1'b0, 9'h108, 32'hABC,       8'd3},
    '{1'b1, 9'h108, 32'h0,         8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        startup_done = 1'b1;
  logic        port_en, port_rdwr;
  logic [31:0] port_wdata, port_rdata;

  int n_chk = 0, n_fail = 0;
  int unsigned beat = 0;
  int stat_left = 0;
  logic prev_en = 1'b0, prev_rw = 1'b0;
  logic [31:0] wq [$];

  always #2.5 clk = ~clk;

  cfgport_xfer_ctrl #(.WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .startup_done(startup_done), .port_en(port_en), .port_rdwr(port_rdwr),
    .port_wdata(port_wdata), .port_rdata(port_rdata));

  // Port model: counts read beats, logs written words, answers an abort with 4 bytes
  assign port_rdata = (stat_left != 0) ? {24'h0, 8'(8'h11 * (5 - stat_left))}
                                       : RBASE + beat;
  always @(posedge clk) begin
    if (port_en && !port_rdwr) wq.push_back(port_wdata);
    if (port_en && port_rdwr) beat <= beat + 1;
    prev_en <= port_en;
    prev_rw <= port_rdwr;
    if (stat_left != 0) stat_left <= stat_left - 1;
    else if (port_en && prev_en && port_rdwr != prev_rw) stat_left <= 4;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [8:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [8:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      reg_read(9'h110, s);
      if (s[0]) break;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int unsigned b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 port_en idle", {31'b0, port_en}, 32'h0);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i].wr) reg_write(VEC[i].addr, VEC[i].val);
      else begin
        reg_read(VEC[i].addr, d);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].val);
      end
    end

    // R2 write transfer
    wq.delete();
    for (int k = 0; k < 3; k++) reg_write(9'h100, 32'hA000_0000 + k);
    reg_read(9'h114, d); check("R2 vacancy after 3", d, 32'd60);
    reg_write(9'h10C, 32'h1);
    wait_done();
    check("R2 word count", wq.size(), 32'd3);
    for (int k = 0; k < 3 && k < wq.size(); k++) check("R2 word order", wq[k], 32'hA000_0000 + k);
    reg_read(9'h10C, d); check("R2 start bit cleared", d, 32'h0);

    // R6 startup gating
    startup_done = 1'b0;
    wq.delete();
    reg_write(9'h100, 32'hB000_0001);
    reg_write(9'h100, 32'hB000_0002);
    reg_write(9'h10C, 32'h1);
    repeat (20) @(negedge clk);
    check("R6 no access before startup", wq.size(), 32'd0);
    reg_read(9'h110, d); check("R6 status eos low", d, 32'h1);
    reg_read(9'h10C, d); check("R6 start pending", d, 32'h1);
    startup_done = 1'b1;
    wait_done();
    check("R6 words after startup", wq.size(), 32'd2);

    // R3 bounded readback, size upper bits ignored
    reg_write(9'h108, 32'h0000_1005);
    b0 = beat;
    reg_write(9'h10C, 32'h2);
    wait_done();
    reg_read(9'h118, d); check("R3 occupancy", d, 32'd5);
    for (int k = 0; k < 5; k++) begin
      reg_read(9'h104, d); check("R3 readback word", d, RBASE + b0 + k);
    end
    reg_read(9'h104, d); check("R10 empty read", d, 32'h0);
    reg_read(9'h10C, d); check("R3 read bit cleared", d, 32'h0);

    // R4 back-pressure and R5 rejected start
    wq.delete();
    reg_write(9'h108, 32'd200);
    b0 = beat;
    reg_write(9'h10C, 32'h2);
    repeat (300) @(negedge clk);
    reg_read(9'h118, d); check("R4 occupancy at full", d, 32'(RD_DEPTH - 1));
    reg_read(9'h110, d); check("R4 busy while stalled", d, 32'h4);
    reg_write(9'h10C, 32'h1);
    reg_read(9'h10C, d); check("R5 start ignored while busy", d, 32'h2);
    for (int k = 0; k < 200; k++) begin
      reg_read(9'h104, d); check("R4 word order", d, RBASE + b0 + k);
    end
    wait_done();
    reg_read(9'h118, d); check("R4 occupancy drained", d, 32'h0);
    check("R5 no write transfer", wq.size(), 32'd0);

    // R5 both start bits written
    b0 = beat;
    reg_write(9'h10C, 32'h3);
    reg_read(9'h10C, d); check("R5 write wins", d, 32'h1);
    wait_done();
    check("R5 no readback", beat, b0);

    // R10 write FIFO full drop
    for (int k = 0; k < 70; k++) reg_write(9'h100, 32'hD000_0000 + k);
    reg_read(9'h114, d); check("R10 vacancy full", d, 32'h0);
    wq.delete();
    reg_write(9'h10C, 32'h1);
    wait_done();
    check("R10 kept words", wq.size(), 32'(WR_DEPTH - 1));
    if (wq.size() > 0) check("R10 last kept word", wq[wq.size() - 1], 32'hD000_0000 + WR_DEPTH - 2);

    // R9 FIFO clear
    for (int k = 0; k < 4; k++) reg_write(9'h100, 32'hE000_0000 + k);
    reg_write(9'h108, 32'd3);
    reg_write(9'h10C, 32'h2);
    wait_done();
    reg_read(9'h118, d); check("R9 occupancy before clear", d, 32'd3);
    reg_write(9'h10C, 32'h4);
    @(negedge clk);
    reg_read(9'h114, d); check("R9 write FIFO cleared", d, 32'h3F);
    reg_read(9'h118, d); check("R9 read FIFO cleared", d, 32'h0);
    reg_read(9'h10C, d); check("R9 clear bit reads 0", d, 32'h0);

    // R7 abort during write
    for (int k = 0; k < 20; k++) reg_write(9'h100, 32'hF000_0000 + k);
    wq.delete();
    reg_write(9'h10C, 32'h1);
    reg_write(9'h10C, 32'h10);
    wait_done();
    reg_read(9'h11C, d); check("R7 abort bytes write", d, 32'h1122_3344);
    reg_read(9'h114, d); check("R7 write FIFO flushed", d, 32'h3F);
    reg_read(9'h10C, d); check("R7 control cleared", d, 32'h0);
    check("R7 transfer cut short", 32'(wq.size() < 20), 32'h1);

    // R8 abort while idle
    for (int k = 0; k < 3; k++) reg_write(9'h100, 32'h1234_0000 + k);
    wq.delete();
    reg_write(9'h10C, 32'h10);
    repeat (2) @(negedge clk);
    reg_read(9'h114, d); check("R8 idle abort flush", d, 32'h3F);
    reg_read(9'h11C, d); check("R8 abort word kept", d, 32'h1122_3344);
    reg_read(9'h10C, d); check("R8 abort bit cleared", d, 32'h0);
    check("R8 no port access", wq.size(), 32'd0);

    // R9 soft reset
    reg_write(9'h108, 32'h77);
    reg_write(9'h10C, 32'h8);
    repeat (2) @(negedge clk);
    reg_read(9'h108, d); check("R9 size reset", d, 32'h0);
    reg_read(9'h11C, d); check("R9 abort word reset", d, 32'h0);
    reg_read(9'h110, d); check("R9 status after soft reset", d, 32'h5);

    // R7 abort during readback
    reg_write(9'h108, 32'd100);
    reg_write(9'h10C, 32'h2);
    reg_write(9'h10C, 32'h10);
    wait_done();
    reg_read(9'h11C, d); check("R7 abort bytes read", d, 32'h1122_3344);
    reg_read(9'h118, d); check("R7 read FIFO flushed", d, 32'h0);
    reg_read(9'h10C, d); check("R7 control cleared read", d, 32'h0);

    finish_run();
  end
endmodule